// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two WIDTH-bit ports, A and B. Each direction has its own storage word. Each word is loaded on the rising edge of its own clock. The A-to-B word captures port A on `clkAtoB`. The B-to-A word captures port B on `clkBtoA`.

Whichever port is driven can carry one of two values:
- the live value from the opposite port, passed through purely combinationally, or
- the stored word for that direction.

A per-direction select makes that choice. An active-low output enable and a direction input decide which port is driven, if either is. When the enable is high, the block isolates both ports, but both words keep capturing.

Each bus pin is modelled as a separate data-in, data-out and output-enable signal, so the block stays fully synthesizable. The output-enable pins can drive tri-state pads at the chip boundary.

Top module: `bus_xcvr_top`

## Requirements
- R1: On every rising edge of `clkAtoB` while `rstN` is high, the A-to-B word takes the value on `aIn`. Between edges it holds its value, even while `aIn` changes.
- R2: On every rising edge of `clkBtoA` while `rstN` is high, the B-to-A word takes the value on `bIn`. Between edges it holds its value.
- R3: Capture into either word is independent of `oeN`, `dir`, `selAB` and `selBA`. This includes capture during isolation.
- R4: While `oeN` is 1, `aOe` and `bOe` are both 0. Both data outputs are then 0.
- R5: While `oeN` is 0, the direction input decides which port is driven:
  - `dir` = 0: `aOe` = 1 and `bOe` = 0.
  - `dir` = 1: `bOe` = 1 and `aOe` = 0.
- R6: When port B is driven, `bOut` equals `aIn` if `selAB` = 0, or the A-to-B word if `selAB` = 1. An undriven port outputs 0.
- R7: When port A is driven, `aOut` equals `bIn` if `selBA` = 0, or the B-to-A word if `selBA` = 1.
- R8: `aOe` and `bOe` are never 1 together.
- R9: While `rstN` is 0, both words are cleared to 0 asynchronously.
- R10: A port driven from a word that captures on the same edge shows the old word before the edge and the newly captured word after it. Live transfer has no clocked stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkAtoB | input | 1 | Capture clock for the A-to-B word |
| clkBtoA | input | 1 | Capture clock for the B-to-A word |
| rstN | input | 1 | Asynchronous active-low clear of both words |
| oeN | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 0 drives port A, 1 drives port B |
| selAB | input | 1 | Source for port B: 0 live A, 1 stored A-to-B word |
| selBA | input | 1 | Source for port A: 0 live B, 1 stored B-to-A word |
| aIn | input | WIDTH | Value seen on port A |
| aOut | output | WIDTH | Value driven onto port A |
| aOe | output | 1 | Port A driver enable |
| bIn | input | WIDTH | Value seen on port B |
| bOut | output | WIDTH | Value driven onto port B |
| bOe | output | 1 | Port B driver enable |

## Verification
Two functions can fall in the same cycle: capture into a word, and driving a port from that same word. The bench provokes this both by directed steps and by random steps in which a word's clock pulses while that word is selected as the driven source. Outputs are sampled just before the edge and just after it. The pre-edge sample must show the previous word and the post-edge sample the new one, as the bench's own model predicts. Steps where capture happens during isolation are judged later, when the port is enabled and shows the stored value.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic driveA;    // port A driver on
    logic driveB;    // port B driver on
    logic aFromReg;  // port A sourced from the B-to-A word
    logic bFromReg;  // port B sourced from the A-to-B word
  } xcvrCtrl_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic      oeN,
  input  logic      dir,
  input  logic      selAB,
  input  logic      selBA,
  output xcvrCtrl_t ctl
);
  always_comb begin
    ctl.driveA   = !oeN && !dir;
    ctl.driveB   = !oeN && dir;
    ctl.aFromReg = selBA;
    ctl.bFromReg = selAB;
  end

  // R8: never drive both ports
  always_comb begin
    p_one_side_r8: assert (!(ctl.driveA && ctl.driveB))
      else $error("both ports driven");
  end

  // R4: isolation leaves both ports undriven
  always_comb begin
    if (oeN) begin
      p_isolate_r4: assert (!ctl.driveA && !ctl.driveB)
        else $error("driver on during isolation");
    end
  end

  // R5: with the enable low, exactly one port is driven
  always_comb begin
    if (!oeN) begin
      p_single_r5: assert (ctl.driveA != ctl.driveB)
        else $error("enabled but not exactly one driver");
    end
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] stored
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stored <= '0;
    else       stored <= dIn;
  end

  // R1 (A-to-B instance) and R2 (B-to-A instance): the word follows
  // the input sampled at the previous edge of its clock
  p_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> stored == $past(dIn))
    else $error("stored word did not capture");
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             rstN,
  input  xcvrCtrl_t        ctl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic             aOe,
  output logic             bOe
);
  localparam int NDIR = 2;  // index 0: A-to-B, index 1: B-to-A

  logic [WIDTH-1:0] srcIn  [NDIR];
  logic [WIDTH-1:0] word   [NDIR];
  logic             capClk [NDIR];

  assign srcIn[0]  = aIn;
  assign srcIn[1]  = bIn;
  assign capClk[0] = clkAtoB;
  assign capClk[1] = clkBtoA;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk    (capClk[d]),
      .rstN   (rstN),
      .dIn    (srcIn[d]),
      .stored (word[d])
    );
  end

  logic [WIDTH-1:0] bSrc, aSrc;
  assign bSrc = ctl.bFromReg ? word[0] : aIn;
  assign aSrc = ctl.aFromReg ? word[1] : bIn;

  assign bOut = ctl.driveB ? bSrc : '0;
  assign aOut = ctl.driveA ? aSrc : '0;
  assign bOe  = ctl.driveB;
  assign aOe  = ctl.driveA;
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             rstN,
  input  logic             oeN,
  input  logic             dir,
  input  logic             selAB,
  input  logic             selBA,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  xcvrCtrl_t ctl;

  xcvr_ctrl u_ctrl (
    .oeN   (oeN),
    .dir   (dir),
    .selAB (selAB),
    .selBA (selBA),
    .ctl   (ctl)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clkAtoB (clkAtoB),
    .clkBtoA (clkBtoA),
    .rstN    (rstN),
    .ctl     (ctl),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .bOut    (bOut),
    .aOe     (aOe),
    .bOe     (bOe)
  );
endmodule

// File: tb/tb_bus_xcvr_top.sv
`timescale 1ns/1ps
module tb_bus_xcvr_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz pacing clock

  logic clkAtoB = 0, clkBtoA = 0, rstN = 0, oeN = 1, dir = 0, selAB = 0, selBA = 0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;

  bus_xcvr_top #(.WIDTH(W)) dut (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rstN(rstN), .oeN(oeN), .dir(dir),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  int nChk = 0, nBad = 0;
  logic [W-1:0] mAB = '0, mBA = '0;  // bench model of the two words

  // {aOe, bOe, aOut, bOut} predicted from the requirements
  function automatic logic [2*W+1:0] expect_out(
      logic o, logic d, logic sab, logic sba,
      logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] wab, logic [W-1:0] wba);
    logic ea, eb;
    logic [W-1:0] va, vb;
    ea = !o && !d;                          // R4, R5
    eb = !o && d;
    va = ea ? (sba ? wba : b) : '0;         // R7
    vb = eb ? (sab ? wab : a) : '0;         // R6
    return {ea, eb, va, vb};
  endfunction

  task automatic check(string req, logic [2*W+1:0] act, logic [2*W+1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_now(string req);
    check(req, {aOe, bOe, aOut, bOut},
          expect_out(oeN, dir, selAB, selBA, aIn, bIn, mAB, mBA));
  endtask

  // One step: inputs applied at the falling edge, checked before the rising
  // edge, the selected capture clocks pulsed at the rising edge, checked after.
  task automatic step(logic o, logic d, logic sab, logic sba,
                      logic [W-1:0] a, logic [W-1:0] b, logic pAB, logic pBA,
                      string req);
    @(negedge clk);
    oeN = o; dir = d; selAB = sab; selBA = sba; aIn = a; bIn = b;
    clkAtoB = 0; clkBtoA = 0;
    #1 check_now(req);
    @(posedge clk);
    clkAtoB = pAB; clkBtoA = pBA;
    if (pAB && rstN) mAB = a;  // R1
    if (pBA && rstN) mBA = b;  // R2
    #1 check_now(req);
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R9: reset state, both words read back as zero through the ports
    repeat (2) @(negedge clk);
    step(0, 1, 1, 0, 8'h5A, 8'hC3, 0, 0, "R9 reset word A-to-B");
    step(0, 0, 0, 1, 8'h5A, 8'hC3, 0, 0, "R9 reset word B-to-A");
    @(negedge clk); rstN = 1;

    // R4, R8: isolation with all selects; R3: both words capture meanwhile
    step(1, 0, 1, 1, 8'h11, 8'h22, 1, 1, "R3 R4 isolation capture");
    step(1, 1, 0, 0, 8'h33, 8'h44, 0, 0, "R4 R8 isolation");
    step(0, 1, 1, 0, 8'h99, 8'h00, 0, 0, "R3 stored A-to-B after isolation");
    step(0, 0, 0, 1, 8'h00, 8'h99, 0, 0, "R3 stored B-to-A after isolation");

    // R6, R7: live transfer in both directions
    step(0, 1, 0, 0, 8'hA5, 8'h0F, 0, 0, "R6 live A to B");
    step(0, 0, 0, 0, 8'hA5, 8'h0F, 0, 0, "R7 live B to A");

    // R10: same-edge capture while driving from that word
    step(0, 1, 1, 0, 8'h7E, 8'h00, 1, 0, "R10 B port same edge");
    step(0, 0, 0, 1, 8'h00, 8'hE7, 0, 1, "R10 A port same edge");

    // R1, R2: clocks held steady, words hold while inputs move
    step(0, 1, 1, 0, 8'h01, 8'h02, 0, 0, "R1 hold while aIn changes");
    step(0, 0, 0, 1, 8'h03, 8'h04, 0, 0, "R2 hold while bIn changes");

    // R3: capture while the opposite port is driven
    step(0, 0, 0, 0, 8'hC8, 8'h8C, 1, 1, "R3 capture with A driven");
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R3 read back A-to-B");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[0], r[1], r[2], r[3], 8'($urandom), 8'($urandom), r[4], r[5],
           "R1 R2 R4 R5 R6 R7 R8 R10 random");
      // R8 checked at the ports
      nChk++;
      if (aOe && bOe) begin
        nBad++;
        $display("FAIL R8 actual=%b%b expected=not both", aOe, bOe);
      end
    end

    // R9: asynchronous reset in the middle of operation
    @(negedge clk); rstN = 0; mAB = '0; mBA = '0;
    step(0, 1, 1, 0, 8'hFF, 8'hFF, 0, 0, "R9 mid-run reset");
    step(0, 0, 0, 1, 8'hFF, 8'hFF, 0, 0, "R9 mid-run reset B-to-A");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule